// File: doc/BRIEF.md
# Card Host Status Flags and Interrupt Line

This block keeps the status word of a memory-card host controller and turns it into one interrupt request. The command and data engines around it send single-cycle pulses when something happens: a busy phase ends, a block finishes, the card signals an SDIO interrupt, or one of five error conditions occurs. Each pulse sets a sticky flag. Software reads the flags over a small register bus and clears them by writing ones to the matching bit positions.

A second register holds the interrupt enables and a few mode bits that other parts of the controller use. Three of the latched events (busy, block, SDIO) can each raise the interrupt through their own enable. The data flag is different. It is not latched. It mirrors a live FIFO-level condition from the data path, appears in bit 0 of the status word for as long as the condition lasts, and drives the interrupt only while its enable is set. The interrupt output is a registered level.

The logic has no sequencing, so there is no state machine. Every register updates independently on each clock edge.

Top module: `host_status_irq`

## Requirements
- R1: After reset, the status flags, the config register and `irq_o` are all 0.
- R2: An event pulse sets its status bit on the rising edge where it is sampled. The bit stays set until it is cleared. Bit positions: 10 busy, 9 block, 8 SDIO, 7 read/erase/write timeout, 6 command timeout, 5 CRC16 error, 4 CRC7 error, 3 FIFO error.
- R3: A write to the status word (`bus_addr` = 0) clears each event bit whose written value is 1 and leaves the others alone. Writing 0x7F8 clears every event bit.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: Writing ones to bits 1, 2 and 0 of the status word has no effect. Bits 1 and 2 always read 0.
- R6: A write to the config word (`bus_addr` = 1) stores bits 10, 8, 5, 4, 3, 2, 1 and 0 (write mask 0x53F). All other config bits read 0. The enables are bit 10 for busy, bit 8 for block, bit 5 for SDIO and bit 4 for data.
- R7: At each rising edge, `irq_o` becomes the OR of four terms, each taken from the values just before that edge: busy flag AND enable bit 10, block flag AND enable bit 8, SDIO flag AND enable bit 5, and data flag AND enable bit 4.
- R8: The error bits (3 to 7) never raise `irq_o`, whatever the config holds.
- R9: Status bit 0 reads the live `fifo_flag_i` with no latching. When the condition drops, bit 0 reads 0 at once and its interrupt term goes away at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 1 | Register select: 0 status, 1 config |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Read data of the selected register (combinational) |
| ev_busy_i | input | 1 | Busy-phase-done event pulse |
| ev_block_i | input | 1 | Block-done event pulse |
| ev_sdio_i | input | 1 | Card SDIO interrupt event pulse |
| ev_rew_tmo_i | input | 1 | Read/erase/write timeout pulse |
| ev_cmd_tmo_i | input | 1 | Command timeout pulse |
| ev_crc16_i | input | 1 | Data CRC error pulse |
| ev_crc7_i | input | 1 | Command CRC error pulse |
| ev_fifo_err_i | input | 1 | FIFO error pulse |
| fifo_flag_i | input | 1 | Live FIFO-level condition |
| irq_o | output | 1 | Registered level interrupt |

## Verification
Read data is combinational from the registers. A pulse or write sampled at edge k therefore shows up on `bus_rdata` just after edge k, and the bench checks it one cycle after it drives the stimulus. `irq_o` adds one more register. A latched event or a config change at edge k reaches the interrupt at edge k+1, so that check is due two cycles after the stimulus. A change of `fifo_flag_i` before edge k reaches `irq_o` at edge k, so that check is due one cycle later. The driver puts each expectation in the scoreboard together with its due cycle. The monitor samples a quarter period after each rising edge and pops only the items that are due in that cycle.

// File: rtl/hsi_pkg.sv
package hsi_pkg;
    localparam int STS_W = 11;

    // Status bit positions
    localparam int B_BUSY    = 10;
    localparam int B_BLOCK   = 9;
    localparam int B_SDIO    = 8;
    localparam int B_REW     = 7;
    localparam int B_CMDTO   = 6;
    localparam int B_CRC16   = 5;
    localparam int B_CRC7    = 4;
    localparam int B_FIFOERR = 3;
    localparam int B_DATA    = 0;

    // Config enable positions
    localparam int E_BUSY  = 10;
    localparam int E_BLOCK = 8;
    localparam int E_SDIO  = 5;
    localparam int E_DATA  = 4;

    localparam logic [STS_W-1:0] EVT_MASK  = 11'h7F8;
    localparam logic [STS_W-1:0] CFG_WMASK = 11'h53F;
    localparam logic [STS_W-1:0] ERR_MASK  = 11'h0F8;

    localparam int IRQ_SRCS = 4;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_CONFIG = 1'b1
    } sel_e;
endpackage

// File: rtl/hsi_flag_bank.sv
module hsi_flag_bank #(
    parameter int W = hsi_pkg::STS_W,
    parameter logic [W-1:0] MASK = hsi_pkg::EVT_MASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] flags
);
    logic unused_bits;
    assign unused_bits = ^(set_vec & ~MASK) ^ ^(clr_vec & ~MASK);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (MASK[i]) begin : g_live
            logic q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= 1'b0;
                else
                    q <= set_vec[i] | (q & ~clr_vec[i]);
            end
            assign flags[i] = q;
        end else begin : g_tied
            assign flags[i] = 1'b0;
        end
    end
endmodule

// File: rtl/hsi_cfg_reg.sv
module hsi_cfg_reg #(
    parameter int W = hsi_pkg::STS_W,
    parameter logic [W-1:0] WMASK = hsi_pkg::CFG_WMASK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cfg
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg <= '0;
        else if (we)
            cfg <= wdata & WMASK;
    end
endmodule

// File: rtl/hsi_irq_merge.sv
module hsi_irq_merge #(
    parameter int N = hsi_pkg::IRQ_SRCS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src,
    input  logic [N-1:0] en,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= |(src & en);
    end
endmodule

// File: rtl/host_status_irq.sv
module host_status_irq #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             ev_busy_i,
    input  logic             ev_block_i,
    input  logic             ev_sdio_i,
    input  logic             ev_rew_tmo_i,
    input  logic             ev_cmd_tmo_i,
    input  logic             ev_crc16_i,
    input  logic             ev_crc7_i,
    input  logic             ev_fifo_err_i,
    input  logic             fifo_flag_i,
    output logic             irq_o
);
    import hsi_pkg::*;

    localparam int PAD_W = REG_W - STS_W;

    logic [STS_W-1:0] set_vec;
    logic [STS_W-1:0] clr_vec;
    logic [STS_W-1:0] flags_q;
    logic [STS_W-1:0] cfg_q;
    logic [STS_W-1:0] sts_view;
    logic [IRQ_SRCS-1:0] irq_src;
    logic [IRQ_SRCS-1:0] irq_en;
    logic             wr_sts;
    logic             wr_cfg;
    logic             unused_hi;

    assign unused_hi = ^bus_wdata[REG_W-1:STS_W];

    assign wr_sts = bus_wr && (sel_e'(bus_addr) == SEL_STATUS);
    assign wr_cfg = bus_wr && (sel_e'(bus_addr) == SEL_CONFIG);

    always_comb begin
        set_vec            = '0;
        set_vec[B_BUSY]    = ev_busy_i;
        set_vec[B_BLOCK]   = ev_block_i;
        set_vec[B_SDIO]    = ev_sdio_i;
        set_vec[B_REW]     = ev_rew_tmo_i;
        set_vec[B_CMDTO]   = ev_cmd_tmo_i;
        set_vec[B_CRC16]   = ev_crc16_i;
        set_vec[B_CRC7]    = ev_crc7_i;
        set_vec[B_FIFOERR] = ev_fifo_err_i;
    end

    assign clr_vec = wr_sts ? (bus_wdata[STS_W-1:0] & EVT_MASK) : '0;

    hsi_flag_bank #(.W(STS_W), .MASK(EVT_MASK)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags_q)
    );

    hsi_cfg_reg #(.W(STS_W), .WMASK(CFG_WMASK)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_cfg),
        .wdata (bus_wdata[STS_W-1:0]),
        .cfg   (cfg_q)
    );

    // Live data flag sits in bit 0 of the status view
    always_comb begin
        sts_view         = flags_q;
        sts_view[B_DATA] = fifo_flag_i;
    end

    assign irq_src = {flags_q[B_BUSY], flags_q[B_BLOCK], flags_q[B_SDIO], fifo_flag_i};
    assign irq_en  = {cfg_q[E_BUSY],   cfg_q[E_BLOCK],   cfg_q[E_SDIO],   cfg_q[E_DATA]};

    hsi_irq_merge #(.N(IRQ_SRCS)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .src   (irq_src),
        .en    (irq_en),
        .irq   (irq_o)
    );

    always_comb begin
        unique case (sel_e'(bus_addr))
            SEL_STATUS: bus_rdata = {{PAD_W{1'b0}}, sts_view};
            SEL_CONFIG: bus_rdata = {{PAD_W{1'b0}}, cfg_q};
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/host_status_irq_chk.sv
module host_status_irq_chk #(
    parameter int REG_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_wr,
    input logic                      bus_addr,
    input logic [REG_W-1:0]          bus_wdata,
    input logic                      ev_busy_i,
    input logic                      ev_block_i,
    input logic                      fifo_flag_i,
    input logic                      irq_o,
    input logic [hsi_pkg::STS_W-1:0] flags_q,
    input logic [hsi_pkg::STS_W-1:0] cfg_q
);
    import hsi_pkg::*;

    AST_BUSY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_busy_i |=> flags_q[B_BUSY]); // R2

    AST_BUSY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[B_BUSY] && !(bus_wr && !bus_addr && bus_wdata[B_BUSY])) |=> flags_q[B_BUSY]); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[B_BUSY] && !ev_busy_i) |=> !flags_q[B_BUSY]); // R3

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_block_i && bus_wr && !bus_addr && bus_wdata[B_BLOCK]) |=> flags_q[B_BLOCK]); // R4

    AST_CFG_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr) |=> (cfg_q[9] == 1'b0 && cfg_q[7:6] == 2'b00)); // R6

    AST_DATA_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_flag_i && cfg_q[E_DATA]) |=> irq_o); // R7

    AST_NO_ERR_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!(flags_q[B_BUSY] && cfg_q[E_BUSY]) && !(flags_q[B_BLOCK] && cfg_q[E_BLOCK]) &&
         !(flags_q[B_SDIO] && cfg_q[E_SDIO]) && !(fifo_flag_i && cfg_q[E_DATA])) |=> !irq_o); // R8
endmodule

bind host_status_irq host_status_irq_chk #(.REG_W(REG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .ev_busy_i   (ev_busy_i),
    .ev_block_i  (ev_block_i),
    .fifo_flag_i (fifo_flag_i),
    .irq_o       (irq_o),
    .flags_q     (flags_q),
    .cfg_q       (cfg_q)
);

// File: tb/sim_host_status_irq.sv
`timescale 1ns/1ps
module sim_host_status_irq;
    localparam int REG_W = 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             bus_wr;
    logic             bus_addr;
    logic [REG_W-1:0] bus_wdata;
    logic [REG_W-1:0] bus_rdata;
    logic ev_busy, ev_block, ev_sdio, ev_rew, ev_cmdto, ev_crc16, ev_crc7, ev_fifoerr;
    logic fifo_flag;
    logic irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        string       req;
        bit          is_irq;
        logic [31:0] val;
    } exp_t;
    exp_t sbq[$];

    always #10 clk = ~clk;

    host_status_irq #(.REG_W(REG_W)) u0 (
        .clk (clk), .rst_n (rst_n),
        .bus_wr (bus_wr), .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .ev_busy_i (ev_busy), .ev_block_i (ev_block), .ev_sdio_i (ev_sdio),
        .ev_rew_tmo_i (ev_rew), .ev_cmd_tmo_i (ev_cmdto), .ev_crc16_i (ev_crc16),
        .ev_crc7_i (ev_crc7), .ev_fifo_err_i (ev_fifoerr),
        .fifo_flag_i (fifo_flag), .irq_o (irq)
    );

    always @(posedge clk) cyc = cyc + 1;

    // Monitor: a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                exp_t e;
                logic [31:0] act;
                e = sbq.pop_front();
                act = e.is_irq ? {31'b0, irq} : bus_rdata;
                checks++;
                if (e.due != cyc || act !== e.val) begin
                    errors++;
                    $display("FAIL %s %s actual=%h expected=%h (due %0d now %0d)",
                             e.req, e.is_irq ? "irq" : "rdata", act, e.val, e.due, cyc);
                end
            end
        end
    end

    task automatic push(string req, bit is_irq, logic [31:0] v, int d);
        exp_t e;
        e.due = cyc + d;
        e.req = req;
        e.is_irq = is_irq;
        e.val = v;
        sbq.push_back(e);
    endtask

    task automatic tick;
        @(negedge clk);
        bus_wr = 1'b0;
        {ev_busy, ev_block, ev_sdio, ev_rew, ev_cmdto, ev_crc16, ev_crc7, ev_fifoerr} = '0;
    endtask

    task automatic wr(logic a, logic [31:0] d);
        bus_wr = 1'b1;
        bus_addr = a;
        bus_wdata = d;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20 * 5000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0; fifo_flag = 1'b0;
        {ev_busy, ev_block, ev_sdio, ev_rew, ev_cmdto, ev_crc16, ev_crc7, ev_fifoerr} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_addr = 1'b0;
        push("R1", 1'b0, 32'h0, 1); push("R1", 1'b1, 32'h0, 1);
        tick();
        bus_addr = 1'b1;
        push("R1", 1'b0, 32'h0, 1);
        tick();

        // R6 config mask
        wr(1'b1, 32'hFFFF_FFFF);
        push("R6", 1'b0, 32'h53F, 1);
        tick();

        // R2 error events latch, R8 they never interrupt
        bus_addr = 1'b0;
        {ev_rew, ev_cmdto, ev_crc16, ev_crc7, ev_fifoerr} = '1;
        push("R2", 1'b0, 32'h0F8, 1); push("R8", 1'b1, 32'h0, 1); push("R8", 1'b1, 32'h0, 2);
        tick();
        push("R2", 1'b0, 32'h0F8, 1);
        tick();

        // R3 write-one-to-clear
        wr(1'b0, 32'h10);
        push("R3", 1'b0, 32'h0E8, 1);
        tick();
        wr(1'b0, 32'h0);
        push("R3", 1'b0, 32'h0E8, 1);
        tick();
        wr(1'b0, 32'h7F8);
        push("R3", 1'b0, 32'h0, 1);
        tick();

        // R5 reserved and data bit writes ignored
        wr(1'b0, 32'h7);
        push("R5", 1'b0, 32'h0, 1);
        tick();

        // R9 live data flag, R7 data interrupt (enable set)
        fifo_flag = 1'b1;
        push("R9", 1'b0, 32'h1, 1); push("R7", 1'b1, 32'h1, 1);
        tick();
        fifo_flag = 1'b0;
        push("R9", 1'b0, 32'h0, 1); push("R9", 1'b1, 32'h0, 1);
        tick();

        // R7 data flag with enable off
        wr(1'b1, 32'h00F);
        push("R6", 1'b0, 32'h00F, 1);
        tick();
        bus_addr = 1'b0;
        fifo_flag = 1'b1;
        push("R9", 1'b0, 32'h1, 1); push("R7", 1'b1, 32'h0, 1); push("R7", 1'b1, 32'h0, 2);
        tick();
        fifo_flag = 1'b0;
        tick();

        // R7 busy event with its enable
        wr(1'b1, 32'h400);
        tick();
        bus_addr = 1'b0;
        ev_busy = 1'b1;
        push("R2", 1'b0, 32'h400, 1); push("R7", 1'b1, 32'h0, 1); push("R7", 1'b1, 32'h1, 2);
        tick();
        wr(1'b0, 32'h400);
        push("R3", 1'b0, 32'h0, 1); push("R7", 1'b1, 32'h1, 1); push("R7", 1'b1, 32'h0, 2);
        tick();

        // R4 set beats clear
        ev_block = 1'b1;
        wr(1'b0, 32'h200);
        push("R4", 1'b0, 32'h200, 1);
        tick();
        wr(1'b1, 32'h100);
        push("R6", 1'b0, 32'h100, 1); push("R7", 1'b1, 32'h1, 2);
        tick();
        wr(1'b0, 32'h7F8);
        push("R7", 1'b1, 32'h0, 2);
        tick();
        tick();

        // R7 SDIO event with its enable, then enable moved away
        wr(1'b1, 32'h020);
        tick();
        bus_addr = 1'b0;
        ev_sdio = 1'b1;
        push("R2", 1'b0, 32'h100, 1); push("R7", 1'b1, 32'h1, 2);
        tick();
        wr(1'b1, 32'h400);
        push("R7", 1'b1, 32'h0, 2);
        tick();

        repeat (3) tick();
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL scoreboard %0d items left actual=%0d expected=0", sbq.size(), sbq.size());
        end
        finish_run();
    end
endmodule